// File: doc/BRIEF.md
# Pipelined Integer Square Root

This block returns the integer square root, rounded down, of an unsigned operand. The operand is zero-extended to an even width. The first few root bits come in one step from a constant table addressed by the top operand bits. The table holds the partial root and partial remainder for every possible top-bit pattern and is computed at elaboration. Each later stage takes the next two operand bits and settles one more root bit. It does this by comparing the shifted remainder against the trial value four times the partial root plus one, and subtracting when the remainder is not smaller.

A parameter chooses where pipeline registers sit:
- Mode 0: none, so the block is pure logic.
- Mode 1: one register at the input and one at the output.
- Mode 2: an input register, then a register after every second stage and after the last stage.
- Mode 3: an input register and a register after every stage.

A valid flag travels through the same registers. An optional clock-enable input freezes all of them at once.

Top module: `isqrt_pipe`

## Requirements
- R1: When `out_valid` is high, `out_root` equals floor(sqrt(x)) for the operand x that was accepted with it. This holds for every x, including 0 and 2^DATA_W-1, and for odd operand widths.
- R2: `out_root` is ceil(DATA_W/2) bits wide. DATA_W must be greater than four.
- R3: With PIPE_MODE=0, `out_valid` and `out_root` follow `in_valid` and `in_op` in the same cycle.
- R4: With PIPE_MODE=1, the latency is 2 enabled clock edges.
- R5: With PIPE_MODE=2, the latency is 1+floor((S+2)/2) enabled clock edges, where S = ceil(DATA_W/2) - SEED_W/2. For DATA_W=16 and SEED_W=6 this is 4.
- R6: With PIPE_MODE=3, the latency is S+2 enabled clock edges. For DATA_W=16 and SEED_W=6 this is 7.
- R7: With HAS_CE=1, a low `ce` holds every pipeline register, so `out_valid` and `out_root` keep their values and no result is lost or repeated. With HAS_CE=0, `ce` has no effect.
- R8: The reset `rst` is synchronous and active high. In a registered mode, `out_valid` is low in the cycle after a clock edge with `rst` high.
- R9: Every accepted input gives exactly one valid output after the mode's latency, at one result per enabled cycle. `out_valid` is never high without a matching input.
- R10: SEED_W is even, between 2 and 10, and at most 2*ceil(DATA_W/2). The root does not depend on its value; only the stage count S changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all pipeline registers (ignored when HAS_CE=0) |
| in_valid | input | 1 | Operand present on `in_op` |
| in_op | input | DATA_W | Unsigned operand |
| out_valid | output | 1 | `out_root` holds a result |
| out_root | output | (DATA_W+1)/2 | Floor of the square root |

## Verification
For a 7-bit operand, every value is swept through two table widths. This separates mistakes in the table seeding from mistakes in the iterative stages. The 16-bit units get perfect squares, values just below a square, zero and the all-ones maximum. These land on the compare boundary, where a wrong `>=` or a wrong trial value shows up. Random operands with random gaps in `in_valid` and random clock-enable stalls separate the four latencies of the register placements, and they catch dropped or duplicated results. A long stall and a mid-stream reset check freezing and the clearing of in-flight data.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  localparam int MODE_COMB = 0;
  localparam int MODE_IO   = 1;
  localparam int MODE_PAIR = 2;
  localparam int MODE_EACH = 3;

  // Whether a register follows stage s (stage 0 is the seed table, last is the final iteration)
  function automatic bit stage_reg(int mode, int s, int last);
    case (mode)
      MODE_EACH: return 1'b1;
      MODE_PAIR: return ((s % 2) == 1) || (s == last);
      MODE_IO:   return s == last;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic int latency(int mode, int last);
    int n;
    n = (mode == MODE_COMB) ? 0 : 1;
    for (int s = 0; s <= last; s++) begin
      if (stage_reg(mode, s, last)) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/isqrt_stage_reg.sv
module isqrt_stage_reg #(
  parameter int W      = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  if (ENABLE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_valid <= 1'b0;
      end else if (ce) begin
        q_valid <= d_valid;
      end
    end
    always_ff @(posedge clk) begin
      if (ce) q <= d;
    end
  end else begin : g_wire
    logic unused_ctl;
    assign unused_ctl = ^{clk, rst, ce};
    assign q_valid = d_valid;
    assign q       = d;
  end

endmodule

// File: rtl/isqrt_seed_rom.sv
module isqrt_seed_rom #(
  parameter int SEED_W = 6,
  parameter int ROOT_W = 8
) (
  input  logic [SEED_W-1:0] addr,
  output logic [ROOT_W-1:0] root,
  output logic [ROOT_W:0]   rem
);

  localparam int HB    = SEED_W / 2;
  localparam int DEPTH = 1 << SEED_W;
  localparam int RMW   = ROOT_W + 1;

  function automatic logic [2*HB:0] seed_word(int a);
    int r;
    int rm;
    logic [31:0] rv;
    logic [31:0] mv;
    r = 0;
    for (int c = 0; c < (1 << HB); c++) begin
      if (c * c <= a) r = c;
    end
    rm = a - r * r;
    rv = r;
    mv = rm;
    return {rv[HB-1:0], mv[HB:0]};
  endfunction

  logic [2*HB:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = seed_word(a);
  end

  logic [2*HB:0] word;
  assign word = rom[addr];
  assign root = ROOT_W'(word[2*HB:HB+1]);
  assign rem  = RMW'(word[HB:0]);

endmodule

// File: rtl/isqrt_iter_stage.sv
module isqrt_iter_stage #(
  parameter int ROOT_W = 8
) (
  input  logic [1:0]        pair,
  input  logic [ROOT_W-1:0] root_i,
  input  logic [ROOT_W:0]   rem_i,
  output logic [ROOT_W-1:0] root_o,
  output logic [ROOT_W:0]   rem_o
);

  logic [ROOT_W+2:0] shifted;
  logic [ROOT_W+2:0] trial;
  logic [ROOT_W+2:0] diff;
  logic              take;

  assign shifted = {rem_i, pair};
  assign trial   = {1'b0, root_i, 2'b01};
  assign diff    = shifted - trial;
  assign take    = shifted >= trial;

  assign root_o = {root_i[ROOT_W-2:0], take};
  assign rem_o  = take ? diff[ROOT_W:0] : shifted[ROOT_W:0];

  logic unused_hi;
  assign unused_hi = ^{diff[ROOT_W+2:ROOT_W+1], shifted[ROOT_W+2:ROOT_W+1], root_i[ROOT_W-1]};

endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe
  import isqrt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEED_W    = 6,
  parameter int PIPE_MODE = MODE_EACH,
  parameter bit HAS_CE    = 1'b1,
  localparam int ROOT_W   = (DATA_W + 1) / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_op,
  output logic              out_valid,
  output logic [ROOT_W-1:0] out_root
);

  localparam int PW = 2 * ROOT_W;
  localparam int NS = ROOT_W - SEED_W / 2;
  localparam int WW = PW + ROOT_W + ROOT_W + 1;

  logic en;
  if (HAS_CE) begin : g_ce
    assign en = ce;
  end else begin : g_noce
    logic unused_ce;
    assign unused_ce = ce;
    assign en = 1'b1;
  end

  // Level k feeds stage k; stage k's result goes through an optional register to level k+1
  logic              lvl_v    [NS+2];
  logic [PW-1:0]     lvl_op   [NS+2];
  logic [ROOT_W-1:0] lvl_root [NS+2];
  logic [ROOT_W:0]   lvl_rem  [NS+2];

  logic              stg_v    [NS+1];
  logic [PW-1:0]     stg_op   [NS+1];
  logic [ROOT_W-1:0] stg_root [NS+1];
  logic [ROOT_W:0]   stg_rem  [NS+1];

  logic [PW-1:0] op_pad;
  assign op_pad = PW'(in_op);

  isqrt_stage_reg #(.W(PW), .ENABLE(PIPE_MODE != MODE_COMB)) u_in_reg (
    .clk(clk), .rst(rst), .ce(en),
    .d_valid(in_valid), .d(op_pad),
    .q_valid(lvl_v[0]), .q(lvl_op[0])
  );
  assign lvl_root[0] = '0;
  assign lvl_rem[0]  = '0;

  isqrt_seed_rom #(.SEED_W(SEED_W), .ROOT_W(ROOT_W)) u_seed (
    .addr(lvl_op[0][PW-1 -: SEED_W]),
    .root(stg_root[0]),
    .rem(stg_rem[0])
  );
  assign stg_v[0]  = lvl_v[0];
  assign stg_op[0] = lvl_op[0];

  logic unused_seed;
  assign unused_seed = ^{lvl_root[0], lvl_rem[0]};

  for (genvar s = 1; s <= NS; s++) begin : g_iter
    localparam int LO = PW - SEED_W - 2 * s;
    isqrt_iter_stage #(.ROOT_W(ROOT_W)) u_stage (
      .pair(lvl_op[s][LO+1:LO]),
      .root_i(lvl_root[s]),
      .rem_i(lvl_rem[s]),
      .root_o(stg_root[s]),
      .rem_o(stg_rem[s])
    );
    assign stg_v[s]  = lvl_v[s];
    assign stg_op[s] = lvl_op[s];
  end

  for (genvar s = 0; s <= NS; s++) begin : g_lvl
    logic [WW-1:0] pk_d;
    logic [WW-1:0] pk_q;
    assign pk_d = {stg_op[s], stg_root[s], stg_rem[s]};
    isqrt_stage_reg #(.W(WW), .ENABLE(stage_reg(PIPE_MODE, s, NS))) u_reg (
      .clk(clk), .rst(rst), .ce(en),
      .d_valid(stg_v[s]), .d(pk_d),
      .q_valid(lvl_v[s+1]), .q(pk_q)
    );
    assign {lvl_op[s+1], lvl_root[s+1], lvl_rem[s+1]} = pk_q;
  end

  assign out_valid = lvl_v[NS+1];
  assign out_root  = lvl_root[NS+1];

  logic unused_tail;
  assign unused_tail = ^{lvl_op[NS+1], lvl_rem[NS+1]};

endmodule

// File: rtl/isqrt_pipe_chk.sv
module isqrt_pipe_chk
  import isqrt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEED_W    = 6,
  parameter int PIPE_MODE = MODE_EACH,
  parameter bit HAS_CE    = 1'b1,
  localparam int ROOT_W   = (DATA_W + 1) / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_op,
  input logic              out_valid,
  input logic [ROOT_W-1:0] out_root
);

  localparam int NS  = ROOT_W - SEED_W / 2;
  localparam int LAT = latency(PIPE_MODE, NS);

  function automatic bit root_ok(logic [DATA_W-1:0] x, logic [ROOT_W-1:0] r);
    longint xv;
    longint rv;
    xv = longint'(x);
    rv = longint'(r);
    return (rv * rv <= xv) && ((rv + 1) * (rv + 1) > xv);
  endfunction

  logic adv;
  assign adv = !HAS_CE || ce;

  if (LAT == 0) begin : g_comb
    // R3: pure logic passes valid straight through
    a_r3_same_cycle: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);
    // R1: root bounds against the current operand
    a_r1_root_bounds: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> root_ok(in_op, out_root));
  end else begin : g_seq
    logic [LAT-1:0]    v_line;
    logic [DATA_W-1:0] d_line [LAT];
    logic              rst_q;

    always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
        v_line <= '0;
      end else if (adv) begin
        v_line[0] <= in_valid;
        for (int i = 1; i < LAT; i++) v_line[i] <= v_line[i-1];
      end
    end
    always_ff @(posedge clk) begin
      if (adv) begin
        d_line[0] <= in_op;
        for (int i = 1; i < LAT; i++) d_line[i] <= d_line[i-1];
      end
    end

    // R9: valid appears exactly after the mode latency
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_line[LAT-1]);
    // R1: root matches the operand accepted LAT enabled edges ago
    a_r1_root_bounds: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> root_ok(d_line[LAT-1], out_root));
    // R8: reset empties the pipeline
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> !out_valid);
    if (HAS_CE) begin : g_hold
      // R7: a low enable freezes the outputs
      a_r7_ce_freeze: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(out_valid) && $stable(out_root)));
    end
  end

endmodule

bind isqrt_pipe isqrt_pipe_chk #(
  .DATA_W(DATA_W), .SEED_W(SEED_W), .PIPE_MODE(PIPE_MODE), .HAS_CE(HAS_CE)
) u_chk (.*);

// File: tb/isqrt_sb.sv
module isqrt_sb #(
  parameter int    DW     = 16,
  parameter int    AW     = 6,
  parameter int    MODE   = 3,
  parameter bit    USE_CE = 1'b1,
  parameter string TAG    = "R6",
  localparam int   RW     = (DW + 1) / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          in_valid,
  input  logic [DW-1:0] in_op,
  input  logic          out_valid,
  input  logic [RW-1:0] out_root,
  output int            n_chk,
  output int            n_fail
);

  localparam int S   = RW - AW / 2;
  localparam int LAT = (MODE == 0) ? 0 : (MODE == 1) ? 2 : (MODE == 2) ? 1 + (S + 2) / 2 : S + 2;
  localparam int IX  = (LAT == 0) ? 0 : LAT - 1;

  bit            hv [16];
  logic [DW-1:0] hd [16];

  function automatic int ref_root(longint x);
    int r = 0;
    while ((longint'(r) + 1) * (longint'(r) + 1) <= x) r++;
    return r;
  endfunction

  initial begin
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 16; i++) begin
      hv[i] = 1'b0;
      hd[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) hv[i] = 1'b0;
    end else if (!USE_CE || ce) begin
      for (int i = 15; i > 0; i--) begin
        hv[i] = hv[i-1];
        hd[i] = hd[i-1];
      end
      hv[0] = in_valid;
      hd[0] = in_op;
    end
  end

  always @(negedge clk) begin
    bit            ev;
    logic [DW-1:0] ed;
    int            er;
    ev = (LAT == 0) ? in_valid : hv[IX];
    ed = (LAT == 0) ? in_op : hd[IX];
    n_chk++;
    if (out_valid !== ev) begin
      n_fail++;
      $display("FAIL %s/R9 valid latency %0d: actual=%0b expected=%0b", TAG, LAT, out_valid, ev);
    end
    if (ev && out_valid) begin
      er = ref_root(longint'(ed));
      n_chk++;
      if (int'(out_root) != er) begin
        n_fail++;
        $display("FAIL R1 (%s) root of %0d: actual=%0d expected=%0d", TAG, ed, out_root, er);
      end
    end
  end

endmodule

// File: tb/isqrt_pipe_tb_top.sv
module isqrt_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op16 = '0;
  logic [6:0]  op7 = '0;

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int sc [8];
  int sf [8];

  logic       v_i, v_m0, v_m1, v_m2, v_s, v_s2, v_a, v_n;
  logic [7:0] r_i, r_m0, r_m1, r_m2, r_a, r_n;
  logic [3:0] r_s, r_s2;

  isqrt_pipe #(.DATA_W(16), .SEED_W(6), .PIPE_MODE(3), .HAS_CE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_i), .out_root(r_i));
  isqrt_pipe #(.DATA_W(16), .SEED_W(6), .PIPE_MODE(0), .HAS_CE(1'b1)) dut_m0 (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_m0), .out_root(r_m0));
  isqrt_pipe #(.DATA_W(16), .SEED_W(6), .PIPE_MODE(1), .HAS_CE(1'b1)) dut_m1 (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_m1), .out_root(r_m1));
  isqrt_pipe #(.DATA_W(16), .SEED_W(6), .PIPE_MODE(2), .HAS_CE(1'b1)) dut_m2 (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_m2), .out_root(r_m2));
  isqrt_pipe #(.DATA_W(7), .SEED_W(4), .PIPE_MODE(2), .HAS_CE(1'b1)) dut_s (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op7), .out_valid(v_s), .out_root(r_s));
  isqrt_pipe #(.DATA_W(7), .SEED_W(2), .PIPE_MODE(3), .HAS_CE(1'b1)) dut_s2 (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op7), .out_valid(v_s2), .out_root(r_s2));
  isqrt_pipe #(.DATA_W(16), .SEED_W(10), .PIPE_MODE(3), .HAS_CE(1'b1)) dut_a (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_a), .out_root(r_a));
  isqrt_pipe #(.DATA_W(16), .SEED_W(6), .PIPE_MODE(1), .HAS_CE(1'b0)) dut_n (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_op(op16), .out_valid(v_n), .out_root(r_n));

  isqrt_sb #(.DW(16), .AW(6),  .MODE(3), .USE_CE(1'b1), .TAG("R6"))  sb_i  (clk, rst, ce, in_valid, op16, v_i,  r_i,  sc[0], sf[0]);
  isqrt_sb #(.DW(16), .AW(6),  .MODE(0), .USE_CE(1'b1), .TAG("R3"))  sb_m0 (clk, rst, ce, in_valid, op16, v_m0, r_m0, sc[1], sf[1]);
  isqrt_sb #(.DW(16), .AW(6),  .MODE(1), .USE_CE(1'b1), .TAG("R4"))  sb_m1 (clk, rst, ce, in_valid, op16, v_m1, r_m1, sc[2], sf[2]);
  isqrt_sb #(.DW(16), .AW(6),  .MODE(2), .USE_CE(1'b1), .TAG("R5"))  sb_m2 (clk, rst, ce, in_valid, op16, v_m2, r_m2, sc[3], sf[3]);
  isqrt_sb #(.DW(7),  .AW(4),  .MODE(2), .USE_CE(1'b1), .TAG("R1"))  sb_s  (clk, rst, ce, in_valid, op7,  v_s,  r_s,  sc[4], sf[4]);
  isqrt_sb #(.DW(7),  .AW(2),  .MODE(3), .USE_CE(1'b1), .TAG("R10")) sb_s2 (clk, rst, ce, in_valid, op7,  v_s2, r_s2, sc[5], sf[5]);
  isqrt_sb #(.DW(16), .AW(10), .MODE(3), .USE_CE(1'b1), .TAG("R10")) sb_a  (clk, rst, ce, in_valid, op16, v_a,  r_a,  sc[6], sf[6]);
  isqrt_sb #(.DW(16), .AW(6),  .MODE(1), .USE_CE(1'b0), .TAG("R7"))  sb_n  (clk, rst, ce, in_valid, op16, v_n,  r_n,  sc[7], sf[7]);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [15:0] d16, logic [6:0] d7, bit c);
    @(posedge clk);
    #1;
    in_valid = v;
    op16 = d16;
    op7 = d7;
    ce = c;
  endtask

  task automatic finish_run();
    for (int k = 0; k < 8; k++) begin
      checks += sc[k];
      failures += sf[k];
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10 - 100);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] snap_r;
    logic       snap_v;

    // R2: result width
    check($bits(r_i) == 8, "R2 width 16-bit", $bits(r_i), 8);
    check($bits(r_s) == 4, "R2 width 7-bit", $bits(r_s), 4);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(v_i == 1'b0, "R8 reset state mode3", v_i, 0);
    check(v_m1 == 1'b0, "R8 reset state mode1", v_m1, 0);
    drive(1'b0, '0, '0, 1'b1);
    rst = 1'b0;

    // Exhaustive 7-bit sweep; 16-bit squares, squares minus one, zero and maximum
    for (int x = 0; x < 128; x++) begin
      logic [15:0] d;
      if (x == 127) d = 16'hFFFF;
      else if (x % 2 == 1) d = 16'(x * x * 4);
      else d = 16'(x * x * 4 - 1);
      drive(1'b1, d, 7'(x), 1'b1);
    end
    drive(1'b1, 16'd0, 7'd0, 1'b1);
    repeat (12) drive(1'b0, '0, '0, 1'b1);

    // Random traffic with gaps and enable stalls
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 4) != 0, 16'($urandom), 7'($urandom), ($urandom % 5) != 0);
    end

    // R7: long stall freezes the registered outputs
    for (int n = 0; n < 10; n++) drive(1'b1, 16'($urandom), 7'($urandom), 1'b1);
    drive(1'b1, 16'($urandom), 7'($urandom), 1'b0);
    @(negedge clk);
    snap_r = r_i;
    snap_v = v_i;
    check(snap_v == 1'b1, "R7 pipeline full before stall", snap_v, 1);
    for (int n = 0; n < 5; n++) begin
      drive(1'b1, 16'($urandom), 7'($urandom), 1'b0);
      @(negedge clk);
      check(r_i == snap_r, "R7 root held while ce low", r_i, snap_r);
      check(v_i == snap_v, "R7 valid held while ce low", v_i, snap_v);
    end
    drive(1'b1, 16'($urandom), 7'($urandom), 1'b1);
    for (int n = 0; n < 10; n++) drive(1'b1, 16'($urandom), 7'($urandom), 1'b1);

    // R8: mid-stream reset flushes in-flight results
    @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(v_i == 1'b0, "R8 flush mode3", v_i, 0);
    check(v_m2 == 1'b0, "R8 flush mode2", v_m2, 0);
    check(v_m1 == 1'b0, "R8 flush mode1", v_m1, 0);
    drive(1'b0, '0, '0, 1'b1);
    rst = 1'b0;
    for (int n = 0; n < 200; n++) drive(1'b1, 16'($urandom), 7'($urandom), ($urandom % 3) != 0);
    repeat (20) drive(1'b0, '0, '0, 1'b1);
    @(negedge clk);
    finish_run();
  end

endmodule